// File: doc/BRIEF.md
# Single-Wire Bus Slave: Reset, Presence and Address Readout

This block is the front end of a slave device on a single-wire, open-drain bus with a pull-up. It takes the bus line as an oversampled input that has already been synchronised to the core clock. It pulls the line low only through its `dq_pull` output. The block recognises bus resets at two speeds and answers each reset with a presence pulse. It then takes in one 8-bit command. If the command is the address-read opcode, it clocks out its 64-bit identity one bit per master-initiated read slot.

The identity is sent least significant bit first, in three parts: the 8-bit family code (parameter, default 36h), then the 48-bit serial number taken from `serial_no`, then an 8-bit check byte. The block works out the check byte itself while it sends the first 56 bits. The opcode the block accepts is set by a status bit, `opcode_alt`. Any other opcode leaves the slave silent until the next reset. The slave never checks the check byte that a master sends back, so no command is ever blocked on its account.

All timings are parameters counted in core clock cycles. Each timing has a standard value and an overdrive value. The bus is the only data path, so the block has no valid/ready stream; every pin is a plain control or data level.

Top module: `ow_addr_slave`

## Requirements
- R1: After `rst_n` is released, `dq_pull` is 0 and the slave stays silent in every read slot until it has seen a bus reset.
- R2: A reset is recognised when the line has been low for RST_STD consecutive cycles while `speed_sel`=0. A shorter low is not a reset and produces no presence pulse.
- R3: After a reset, once the line returns high, the slave waits GAP cycles and then holds `dq_pull`=1 for about PLEN cycles. It drives nothing during the gap.
- R4: With `speed_sel`=1 the reset threshold is RST_OVD and the gap, presence, sample and hold timings use their overdrive values. The speed is captured when the reset is recognised, so a later change of `speed_sel` leaves the running transaction's timing unchanged.
- R5: The command is received as 8 write slots, least significant bit first. Each bit is the line level SAMP cycles after the master's falling edge (low = 0).
- R6: The accepted opcode is 33h when `opcode_alt`=0 and 39h when `opcode_alt`=1. Any other byte leaves the slave silent in every later slot until the next reset.
- R7: After a valid opcode, 64 read slots return the address least significant bit first: bits 0-7 are the family code, bits 8-55 are `serial_no[0..47]`, and bits 56-63 are the check byte. A 0 is sent by pulling the line low for HOLD cycles from the master's falling edge; a 1 is sent by never pulling.
- R8: The check byte is the CRC with polynomial x^8+x^5+x^4+1 taken over address bits 0..55. The shift register starts at zero, takes the bits in order and shifts right (reflected form, constant 8Ch).
- R9: A reset recognised in any state aborts the transaction at once, releases the line and starts a new presence sequence.
- R10: Once all 64 address bits have been sent, the slave stays silent in further read slots until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| dq_in | input | 1 | Synchronised bus level (1 = high) |
| speed_sel | input | 1 | 0 = standard timing, 1 = overdrive timing |
| opcode_alt | input | 1 | Chooses the address-read opcode (0: 33h, 1: 39h) |
| serial_no | input | 48 | Serial number field of the address |
| dq_pull | output | 1 | 1 turns on the open-drain pull-down |

## Verification
The assertions assume that `dq_in` shows the slave's own pull-down, so the line reads low whenever `dq_pull` is 1. They also assume that every slave-driven low (presence, data 0) is shorter than the reset threshold in force. Finally, they assume that `speed_sel` and `opcode_alt` only change while the bus is idle. The bench models the line as a wired-AND of the master's drive and `dq_pull`. It keeps every master low pulse well away from the sample points and below the thresholds. The one change of `speed_sel` inside a transaction is made on purpose: it checks that the captured speed governs the timing.

// File: rtl/ow_pkg.sv
package ow_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for the first bus reset
    ST_RST,    // reset low in progress
    ST_GAP,    // delay before presence
    ST_PRES,   // driving presence
    ST_CMD,    // receiving command byte
    ST_ADDR,   // sending the 64-bit address
    ST_HALT    // silent until the next reset
  } ow_state_t;

  localparam int ADDR_BITS   = 64;
  localparam int FAMILY_BITS = 8;
  localparam int SERIAL_BITS = 48;
  localparam int CRC_START   = FAMILY_BITS + SERIAL_BITS;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ow_low_timer.sv
module ow_low_timer #(
  parameter int RST_STD = 1200,
  parameter int RST_OVD = 160
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dq_in,
  input  logic speed_sel,
  output logic reset_hit
);
  import ow_pkg::*;

  localparam int CW = $clog2(imax(RST_STD, RST_OVD) + 2);
  localparam logic [CW-1:0] TH_STD = CW'(RST_STD - 1);
  localparam logic [CW-1:0] TH_OVD = CW'(RST_OVD - 1);
  localparam logic [CW-1:0] CMAX   = '1;

  logic [CW-1:0] low_cnt;

  // consecutive-low counter, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                low_cnt <= '0;
    else if (dq_in)            low_cnt <= '0;
    else if (low_cnt != CMAX)  low_cnt <= low_cnt + 1'b1;
  end

  // fires once, on the cycle the low run reaches the threshold
  assign reset_hit = !dq_in && (low_cnt == (speed_sel ? TH_OVD : TH_STD));

  assert_single_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reset_hit |=> !reset_hit);

  assert_low_before_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reset_hit |-> !$past(dq_in));

endmodule

// File: rtl/ow_slot.sv
module ow_slot #(
  parameter int SAMP_STD = 300,
  parameter int SAMP_OVD = 40,
  parameter int HOLD_STD = 300,
  parameter int HOLD_OVD = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic dq_in,
  input  logic ovd,
  input  logic rx_en,
  input  logic tx_en,
  input  logic tx_bit,
  output logic rx_valid,
  output logic rx_bit,
  output logic tx_done,
  output logic pull
);
  import ow_pkg::*;

  localparam int CW = $clog2(imax(imax(SAMP_STD, SAMP_OVD), imax(HOLD_STD, HOLD_OVD)) + 2);
  localparam logic [CW-1:0] SMP_S = CW'(SAMP_STD);
  localparam logic [CW-1:0] SMP_O = CW'(SAMP_OVD);
  localparam logic [CW-1:0] HLD_S = CW'(HOLD_STD);
  localparam logic [CW-1:0] HLD_O = CW'(HOLD_OVD);

  logic          dq_prev, busy, is_tx;
  logic [CW-1:0] cnt;
  logic          fall;
  logic [CW-1:0] samp_lim, hold_lim;

  assign fall     = dq_prev && !dq_in;
  assign samp_lim = ovd ? SMP_O : SMP_S;
  assign hold_lim = ovd ? HLD_O : HLD_S;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_prev  <= 1'b1;
      busy     <= 1'b0;
      is_tx    <= 1'b0;
      cnt      <= '0;
      pull     <= 1'b0;
      rx_valid <= 1'b0;
      rx_bit   <= 1'b0;
      tx_done  <= 1'b0;
    end else begin
      dq_prev  <= dq_in;
      rx_valid <= 1'b0;
      tx_done  <= 1'b0;
      if (clr) begin
        busy <= 1'b0;
        pull <= 1'b0;
      end else if (!busy) begin
        if (fall && (rx_en || tx_en)) begin
          busy  <= 1'b1;
          is_tx <= tx_en;
          cnt   <= CW'(1);
          pull  <= tx_en && !tx_bit;
        end
      end else begin
        cnt <= cnt + 1'b1;
        if (!is_tx && cnt == samp_lim) begin
          rx_valid <= 1'b1;
          rx_bit   <= dq_in;
          busy     <= 1'b0;
        end
        if (is_tx && cnt == hold_lim) begin
          pull    <= 1'b0;
          tx_done <= 1'b1;
          busy    <= 1'b0;
        end
      end
    end
  end

  assert_rx_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_pull_ends_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pull) |-> (tx_done || $past(clr)));

endmodule

// File: rtl/ow_crc8.sv
module ow_crc8 #(
  parameter logic [7:0] POLY_REFL = 8'h8C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic       din,
  output logic [7:0] crc
);

  logic fb;
  assign fb = crc[0] ^ din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (en)  crc <= {1'b0, crc[7:1]} ^ (fb ? POLY_REFL : 8'h00);
  end

  assert_crc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(crc));

endmodule

// File: rtl/ow_addr_slave.sv
module ow_addr_slave #(
  parameter logic [7:0] FAMILY   = 8'h36,
  parameter logic [7:0] OP_BASE  = 8'h33,
  parameter logic [7:0] OP_ALT   = 8'h39,
  parameter int RST_STD  = 1200,
  parameter int RST_OVD  = 160,
  parameter int GAP_STD  = 300,
  parameter int GAP_OVD  = 30,
  parameter int PLEN_STD = 1000,
  parameter int PLEN_OVD = 100,
  parameter int SAMP_STD = 300,
  parameter int SAMP_OVD = 40,
  parameter int HOLD_STD = 300,
  parameter int HOLD_OVD = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dq_in,
  input  logic        speed_sel,
  input  logic        opcode_alt,
  input  logic [47:0] serial_no,
  output logic        dq_pull
);
  import ow_pkg::*;

  localparam int CW = $clog2(imax(imax(GAP_STD, GAP_OVD), imax(PLEN_STD, PLEN_OVD)) + 2);
  localparam logic [CW-1:0] GAP_S  = CW'(GAP_STD);
  localparam logic [CW-1:0] GAP_O  = CW'(GAP_OVD);
  localparam logic [CW-1:0] PLEN_S = CW'(PLEN_STD);
  localparam logic [CW-1:0] PLEN_O = CW'(PLEN_OVD);
  localparam logic [6:0] LAST_ADDR = 7'(ADDR_BITS - 1);
  localparam logic [6:0] FAM_END   = 7'(FAMILY_BITS);
  localparam logic [6:0] CRC_BEG   = 7'(CRC_START);

  ow_state_t     state;
  logic          ovd_q;
  logic [CW-1:0] tcnt;
  logic [6:0]    bitcnt;
  logic [7:0]    cmd_sr, cmd_next;
  logic          pres_pull;
  logic          reset_hit;
  logic          rx_valid, rx_bit, tx_done, slot_pull;
  logic          addr_bit;
  logic [7:0]    crc;
  logic [CW-1:0] gap_lim, plen_lim;
  logic [7:0]    op_sel;

  ow_low_timer #(.RST_STD(RST_STD), .RST_OVD(RST_OVD)) u_low (
    .clk(clk), .rst_n(rst_n), .dq_in(dq_in), .speed_sel(speed_sel),
    .reset_hit(reset_hit));

  ow_slot #(.SAMP_STD(SAMP_STD), .SAMP_OVD(SAMP_OVD),
            .HOLD_STD(HOLD_STD), .HOLD_OVD(HOLD_OVD)) u_slot (
    .clk(clk), .rst_n(rst_n), .clr(reset_hit), .dq_in(dq_in), .ovd(ovd_q),
    .rx_en(state == ST_CMD), .tx_en(state == ST_ADDR), .tx_bit(addr_bit),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .tx_done(tx_done), .pull(slot_pull));

  ow_crc8 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(state != ST_ADDR),
    .en(tx_done && state == ST_ADDR && bitcnt < CRC_BEG),
    .din(addr_bit), .crc(crc));

  assign gap_lim  = ovd_q ? GAP_O : GAP_S;
  assign plen_lim = ovd_q ? PLEN_O : PLEN_S;
  assign op_sel   = opcode_alt ? OP_ALT : OP_BASE;
  assign cmd_next = {rx_bit, cmd_sr[7:1]};
  assign dq_pull  = pres_pull | slot_pull;

  // address bit currently due: family, then serial, then check byte
  always_comb begin
    if (bitcnt < FAM_END)      addr_bit = FAMILY[3'(bitcnt)];
    else if (bitcnt < CRC_BEG) addr_bit = serial_no[6'(bitcnt - FAM_END)];
    else                       addr_bit = crc[3'(bitcnt - CRC_BEG)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ovd_q     <= 1'b0;
      tcnt      <= '0;
      bitcnt    <= '0;
      cmd_sr    <= '0;
      pres_pull <= 1'b0;
    end else if (reset_hit) begin
      state     <= ST_RST;
      ovd_q     <= speed_sel;
      pres_pull <= 1'b0;
      tcnt      <= '0;
      bitcnt    <= '0;
    end else begin
      case (state)
        ST_RST: if (dq_in) begin
          state <= ST_GAP;
          tcnt  <= CW'(1);
        end
        ST_GAP: if (tcnt == gap_lim) begin
          state     <= ST_PRES;
          pres_pull <= 1'b1;
          tcnt      <= CW'(1);
        end else tcnt <= tcnt + 1'b1;
        ST_PRES: if (tcnt == plen_lim) begin
          state     <= ST_CMD;
          pres_pull <= 1'b0;
          bitcnt    <= '0;
        end else tcnt <= tcnt + 1'b1;
        ST_CMD: if (rx_valid) begin
          cmd_sr <= cmd_next;
          if (bitcnt == 7'd7) begin
            state  <= (cmd_next == op_sel) ? ST_ADDR : ST_HALT;
            bitcnt <= '0;
          end else bitcnt <= bitcnt + 1'b1;
        end
        ST_ADDR: if (tx_done) begin
          if (bitcnt == LAST_ADDR) state <= ST_HALT;
          else bitcnt <= bitcnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assert_pull_only_when_allowed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dq_pull |-> (state == ST_PRES || state == ST_ADDR));

  assert_gap_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP) |-> !dq_pull);

  assert_reset_aborts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_hit |=> (state == ST_RST && !dq_pull));

  assert_halt_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT) |-> !dq_pull);

endmodule

// File: tb/ow_addr_slave_tb.sv
module ow_addr_slave_tb_top;

  localparam int RSTS = 200, RSTO = 40, GAPS = 20, GAPO = 5, PLS = 100, PLO = 20;
  localparam int SMS = 30, SMO = 8, HDS = 30, HDO = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        master_low = 1'b0;
  logic        speed_sel = 1'b0;
  logic        opcode_alt = 1'b0;
  logic [47:0] serial_no = 48'hA5C3_0F12_7E91;
  logic        dq_pull;
  logic        dq_in;

  int n_tests = 0;
  int n_fail  = 0;

  bit    exp_q[$];
  bit    obs_q[$];
  string tag_q[$];
  event  obs_e;

  always #5 clk = ~clk;
  assign dq_in = !(master_low || dq_pull);

  ow_addr_slave #(
    .RST_STD(RSTS), .RST_OVD(RSTO), .GAP_STD(GAPS), .GAP_OVD(GAPO),
    .PLEN_STD(PLS), .PLEN_OVD(PLO), .SAMP_STD(SMS), .SAMP_OVD(SMO),
    .HOLD_STD(HDS), .HOLD_OVD(HDO)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .dq_in(dq_in), .speed_sel(speed_sel),
    .opcode_alt(opcode_alt), .serial_no(serial_no), .dq_pull(dq_pull));

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // independent model of the check byte (R8)
  function automatic logic [7:0] ref_crc(logic [55:0] d);
    logic [7:0] r;
    logic fb;
    r = 8'h00;
    for (int i = 0; i < 56; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ 8'h8C;
    end
    return r;
  endfunction

  function automatic logic [63:0] ref_addr(logic [47:0] sn);
    logic [55:0] body;
    body = {sn, 8'h36};
    return {ref_crc(body), body};
  endfunction

  // scoreboard monitor
  initial begin
    forever begin
      @(obs_e);
      while (obs_q.size() > 0 && exp_q.size() > 0) begin
        bit e, o;
        string t;
        e = exp_q.pop_front();
        o = obs_q.pop_front();
        t = tag_q.pop_front();
        chk(o == e, t, 64'(o), 64'(e));
      end
    end
  end

  task automatic bus_reset(int low_cycles);
    master_low = 1'b1;
    repeat (low_cycles) @(negedge clk);
    master_low = 1'b0;
  endtask

  task automatic pres_check(int gap, int plen, string tag);
    for (int k = 1; k <= gap + plen + 3; k++) begin
      @(negedge clk);
      if (k == gap / 2)        chk(dq_pull == 1'b0, {tag, " gap"}, 64'(dq_pull), 64'd0);
      if (k == gap + plen / 2) chk(dq_pull == 1'b1, {tag, " presence"}, 64'(dq_pull), 64'd1);
      if (k == gap + plen + 3) chk(dq_pull == 1'b0, {tag, " release"}, 64'(dq_pull), 64'd0);
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic wr_byte(logic [7:0] b, bit ovd);
    for (int i = 0; i < 8; i++) begin
      int low, slot;
      low  = b[i] ? (ovd ? 1 : 3) : (ovd ? 12 : 50);
      slot = ovd ? 18 : 70;
      master_low = 1'b1;
      repeat (low) @(negedge clk);
      master_low = 1'b0;
      repeat (slot - low) @(negedge clk);
    end
  endtask

  task automatic rd_bit(bit ovd, output bit b);
    int low, smp, slot;
    low  = ovd ? 1 : 2;
    smp  = ovd ? 4 : 12;
    slot = ovd ? 18 : 70;
    master_low = 1'b1;
    repeat (low) @(negedge clk);
    master_low = 1'b0;
    repeat (smp - low) @(negedge clk);
    b = dq_in;
    repeat (slot - smp) @(negedge clk);
  endtask

  // driver: pushes expected bits, then performs the read slots
  task automatic rd_expect(int n, bit ovd, logic [63:0] v, string tag);
    for (int i = 0; i < n; i++) begin
      bit b;
      exp_q.push_back(v[i]);
      tag_q.push_back(tag);
      rd_bit(ovd, b);
      obs_q.push_back(b);
      -> obs_e;
    end
  endtask

  task automatic finish_up();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    bit any;
    repeat (4) @(negedge clk);
    chk(dq_pull == 1'b0, "R1 reset state", 64'(dq_pull), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: slots before any bus reset are ignored
    wr_byte(8'h33, 1'b0);
    rd_expect(8, 1'b0, '1, "R1 silent before reset");

    // R2: low shorter than threshold is not a reset
    bus_reset(RSTS - 50);
    any = 1'b0;
    for (int k = 0; k < 150; k++) begin
      @(negedge clk);
      any |= dq_pull;
    end
    chk(any == 1'b0, "R2 short low no presence", 64'(any), 64'd0);

    // R2/R3/R5/R7/R8/R10: standard transaction, base opcode
    bus_reset(RSTS + 50);
    pres_check(GAPS, PLS, "R3 std");
    wr_byte(8'h33, 1'b0);
    rd_expect(64, 1'b0, ref_addr(serial_no), "R7 R8 std address");
    rd_expect(8, 1'b0, '1, "R10 silent after 64 bits");

    // R6: alternate opcode selected, base opcode rejected
    serial_no  = 48'h0000_0000_0001;
    opcode_alt = 1'b1;
    bus_reset(RSTS + 50);
    pres_check(GAPS, PLS, "R6 std");
    wr_byte(8'h33, 1'b0);
    rd_expect(8, 1'b0, '1, "R6 wrong opcode silent");
    bus_reset(RSTS + 50);
    pres_check(GAPS, PLS, "R6 std");
    wr_byte(8'h39, 1'b0);
    rd_expect(64, 1'b0, ref_addr(serial_no), "R6 R8 alt opcode address");

    // R4: overdrive threshold and timing, speed captured at reset
    serial_no  = 48'h8001_FEDC_BA98;
    opcode_alt = 1'b0;
    speed_sel  = 1'b1;
    repeat (4) @(negedge clk);
    bus_reset(RSTO + 5);
    speed_sel = 1'b0;
    pres_check(GAPO, PLO, "R4 ovd");
    wr_byte(8'h33, 1'b1);
    rd_expect(64, 1'b1, ref_addr(serial_no), "R4 R5 ovd address");

    // R9: reset in the middle of the address aborts and restarts
    bus_reset(RSTS + 50);
    pres_check(GAPS, PLS, "R9 std");
    wr_byte(8'h33, 1'b0);
    rd_expect(10, 1'b0, ref_addr(serial_no), "R9 partial");
    bus_reset(RSTS + 50);
    pres_check(GAPS, PLS, "R9 restart");
    wr_byte(8'h33, 1'b0);
    rd_expect(64, 1'b0, ref_addr(serial_no), "R9 full after abort");

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", 64'(exp_q.size()), 64'd0);
    finish_up();
  end

endmodule